// File: doc/BRIEF.md
# Ethernet PHY Status LED Driver

This block produces five active-low indicator outputs for a transceiver that runs at 10 or 100 Mb/s. It takes single-cycle event strobes for transmit, receive and collision. It also takes level status inputs for link, duplex, polarity, descrambler lock, disconnect detection and line speed. Three configuration bits come from a register file held elsewhere. These bits select what two of the outputs mean, and how the duplex/polarity output behaves at 10 Mb/s.

Event indications pass through retriggerable pulse stretchers, so that a one-clock strobe stays visible to the eye. Level indications are only registered. When a configuration bit changes an output's meaning, the stretcher behind that output is cleared. A separate bit holds the isolate control. It takes its value from a strap input while reset is high, and software writes replace that value afterwards.

Top module: `phy_led_driver`

## Requirements
- R1: While `rst` is high, every LED output is driven to 1 (off) at each clock edge, and all stretch state is cleared. A 0 on any LED output means "indication on".
- R2: With `cfg_tx_disc_sel` = 0, an event on `tx_evt` sampled at a clock edge drives `led_tx_n` low after that edge. The output stays low for exactly STRETCH_CYCLES clocks after the last event, and every new event restarts the hold.
- R3: With `cfg_tx_disc_sel` = 1, `led_tx_n` shows the inverse of `disc_det` as a level, and `tx_evt` has no effect on it.
- R4: `led_rx_n` shows `rx_evt` through a retriggerable stretcher with the same hold as R2.
- R5: `led_link_n` shows the inverse of `link_ok` as a level, with no stretching.
- R6: With `spd_100` = 1, `led_dpx_n` shows the inverse of `fdx`.
- R7: With `spd_100` = 0, `led_dpx_n` shows the inverse of `fdx` when `cfg_10m_fdx_sel` = 1, and the inverse of `pol_ok` when it is 0.
- R8: With `cfg_lock_sel` = 0, `led_col_n` shows `col_evt` through a retriggerable stretcher. With `cfg_lock_sel` = 1, it shows the inverse of `dscr_lock` as a level, and collisions are ignored.
- R9: A change in `cfg_tx_disc_sel` or `cfg_lock_sel` clears the stretcher of the affected output. An event shown before the switch is therefore not shown again after switching back.
- R10: While `rst` is high, `iso_ctl` takes the value of `iso_strap` at each clock edge.
- R11: After reset, a clock edge with `iso_wr_en` = 1 loads `iso_wr_data` into `iso_ctl`. Otherwise `iso_ctl` holds its value, and `iso_strap` has no effect.
- R12: Each LED output is registered. It changes on the first clock edge at which its selected source has changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_evt | input | 1 | Transmit event strobe |
| rx_evt | input | 1 | Receive event strobe |
| col_evt | input | 1 | Collision event strobe |
| link_ok | input | 1 | Valid link status |
| fdx | input | 1 | Full-duplex status |
| pol_ok | input | 1 | Good receive polarity status (10 Mb/s) |
| dscr_lock | input | 1 | Descrambler locked status (100 Mb/s) |
| disc_det | input | 1 | Disconnect detected status |
| spd_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| cfg_tx_disc_sel | input | 1 | 1 = transmit LED shows disconnect detect |
| cfg_10m_fdx_sel | input | 1 | At 10 Mb/s: 1 = duplex LED shows full duplex, 0 = polarity |
| cfg_lock_sel | input | 1 | 1 = collision LED shows descrambler lock |
| iso_strap | input | 1 | Isolate default strap, sampled during reset |
| iso_wr_en | input | 1 | Software write strobe for the isolate bit |
| iso_wr_data | input | 1 | Software write value for the isolate bit |
| iso_ctl | output | 1 | Isolate control bit |
| led_tx_n | output | 1 | Transmit activity / disconnect LED, active low |
| led_rx_n | output | 1 | Receive activity LED, active low |
| led_link_n | output | 1 | Link LED, active low |
| led_dpx_n | output | 1 | Duplex / polarity LED, active low |
| led_col_n | output | 1 | Collision / lock LED, active low |

## Verification
The hardest case to reach is a change of function while a stretcher is still holding. Only the order "event, switch away, switch back while the old hold would still be running" shows whether the stale count was really discarded. The stimulus sets up this order on purpose for both the transmit and collision outputs, using a short stretch length. A long pseudo-random phase follows, where the configuration bits toggle often enough to hit the same case at many different counter values. A cycle-accurate behavioural model checks all of this on every clock.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;
  localparam int NUM_EV = 3;
  typedef enum int {
    EV_TX  = 0,
    EV_RX  = 1,
    EV_COL = 2
  } ev_idx_e;
endpackage

// File: rtl/led_stretcher.sv
module led_stretcher #(
  parameter int STRETCH_CYCLES = 1 << 22,
  parameter int CNT_W          = $clog2(STRETCH_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic evt,
  output logic on_nxt
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(STRETCH_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr)               cnt_d = '0;
    else if (evt)          cnt_d = LOAD;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = '0;
  end

  assign on_nxt = (cnt_d != '0);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R2: without a new event or clear, the hold counts down by one per clock
  a_r2_countdown: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0 && !evt && !clr) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R1: reset leaves the stretcher idle
  a_r1_idle_after_reset: assert property (@(posedge clk)
    rst |=> (cnt_q == '0));
endmodule

// File: rtl/iso_latch.sv
module iso_latch (
  input  logic clk,
  input  logic rst,
  input  logic strap,
  input  logic wr_en,
  input  logic wr_data,
  output logic iso_q
);
  always_ff @(posedge clk) begin
    if (rst)        iso_q <= strap;
    else if (wr_en) iso_q <= wr_data;
  end

  // R10: strap sampled while in reset
  a_r10_strap: assert property (@(posedge clk)
    rst |=> (iso_q == $past(strap)));

  // R11: outside reset, only a write moves the bit
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(iso_q));
endmodule

// File: rtl/phy_led_driver.sv
module phy_led_driver #(
  parameter int STRETCH_CYCLES = 1 << 22
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_evt,
  input  logic rx_evt,
  input  logic col_evt,
  input  logic link_ok,
  input  logic fdx,
  input  logic pol_ok,
  input  logic dscr_lock,
  input  logic disc_det,
  input  logic spd_100,
  input  logic cfg_tx_disc_sel,
  input  logic cfg_10m_fdx_sel,
  input  logic cfg_lock_sel,
  input  logic iso_strap,
  input  logic iso_wr_en,
  input  logic iso_wr_data,
  output logic iso_ctl,
  output logic led_tx_n,
  output logic led_rx_n,
  output logic led_link_n,
  output logic led_dpx_n,
  output logic led_col_n
);
  import phy_led_pkg::*;

  localparam int CNT_W = $clog2(STRETCH_CYCLES + 1);

  logic [NUM_EV-1:0] ev_in, ev_clr, ev_on;
  logic tx_sel_q, lock_sel_q;
  logic tx_src, dpx_src, col_src;

  always_ff @(posedge clk) begin
    tx_sel_q   <= cfg_tx_disc_sel;
    lock_sel_q <= cfg_lock_sel;
  end

  // Events are gated while their output shows another function
  assign ev_in[EV_TX]   = tx_evt & ~cfg_tx_disc_sel;
  assign ev_in[EV_RX]   = rx_evt;
  assign ev_in[EV_COL]  = col_evt & ~cfg_lock_sel;
  assign ev_clr[EV_TX]  = cfg_tx_disc_sel ^ tx_sel_q;
  assign ev_clr[EV_RX]  = 1'b0;
  assign ev_clr[EV_COL] = cfg_lock_sel ^ lock_sel_q;

  for (genvar i = 0; i < NUM_EV; i++) begin : g_str
    led_stretcher #(
      .STRETCH_CYCLES(STRETCH_CYCLES),
      .CNT_W         (CNT_W)
    ) u_str (
      .clk   (clk),
      .rst   (rst),
      .clr   (ev_clr[i]),
      .evt   (ev_in[i]),
      .on_nxt(ev_on[i])
    );
  end

  always_comb begin
    tx_src  = cfg_tx_disc_sel ? disc_det : ev_on[EV_TX];
    col_src = cfg_lock_sel ? dscr_lock : ev_on[EV_COL];
    if (spd_100)              dpx_src = fdx;
    else if (cfg_10m_fdx_sel) dpx_src = fdx;
    else                      dpx_src = pol_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      led_tx_n   <= 1'b1;
      led_rx_n   <= 1'b1;
      led_link_n <= 1'b1;
      led_dpx_n  <= 1'b1;
      led_col_n  <= 1'b1;
    end else begin
      led_tx_n   <= ~tx_src;
      led_rx_n   <= ~ev_on[EV_RX];
      led_link_n <= ~link_ok;
      led_dpx_n  <= ~dpx_src;
      led_col_n  <= ~col_src;
    end
  end

  iso_latch u_iso (
    .clk    (clk),
    .rst    (rst),
    .strap  (iso_strap),
    .wr_en  (iso_wr_en),
    .wr_data(iso_wr_data),
    .iso_q  (iso_ctl)
  );

  a_r1_leds_off: assert property (@(posedge clk)
    rst |=> (led_tx_n && led_rx_n && led_link_n && led_dpx_n && led_col_n));

  a_r5_link_level: assert property (@(posedge clk) disable iff (rst)
    link_ok |=> !led_link_n);

  a_r6_dpx_100: assert property (@(posedge clk) disable iff (rst)
    spd_100 |=> (led_dpx_n == !$past(fdx)));

  a_r7_pol_10: assert property (@(posedge clk) disable iff (rst)
    (!spd_100 && !cfg_10m_fdx_sel) |=> (led_dpx_n == !$past(pol_ok)));

  a_r3_disc_level: assert property (@(posedge clk) disable iff (rst)
    cfg_tx_disc_sel |=> (led_tx_n == !$past(disc_det)));

  // R9: a function switch leaves the stretcher empty
  a_r9_switch_clears: assert property (@(posedge clk) disable iff (rst)
    (cfg_tx_disc_sel != tx_sel_q) |-> !ev_on[EV_TX]);

  a_r8_lock_level: assert property (@(posedge clk) disable iff (rst)
    cfg_lock_sel |=> (led_col_n == !$past(dscr_lock)));
endmodule

// File: tb/phy_led_driver_tb.sv
module phy_led_driver_tb;
  localparam int S = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_evt = 0, rx_evt = 0, col_evt = 0;
  logic link_ok = 0, fdx = 0, pol_ok = 0, dscr_lock = 0, disc_det = 0, spd_100 = 0;
  logic cfg_tx_disc_sel = 0, cfg_10m_fdx_sel = 0, cfg_lock_sel = 0;
  logic iso_strap = 1, iso_wr_en = 0, iso_wr_data = 0;
  logic iso_ctl, led_tx_n, led_rx_n, led_link_n, led_dpx_n, led_col_n;

  int checks = 0, errors = 0, cyc = 0;
  bit started = 0;
  string phase = "init";

  always #2 clk = ~clk;

  phy_led_driver #(.STRETCH_CYCLES(S)) u_dut (
    .clk(clk), .rst(rst), .tx_evt(tx_evt), .rx_evt(rx_evt), .col_evt(col_evt),
    .link_ok(link_ok), .fdx(fdx), .pol_ok(pol_ok), .dscr_lock(dscr_lock),
    .disc_det(disc_det), .spd_100(spd_100), .cfg_tx_disc_sel(cfg_tx_disc_sel),
    .cfg_10m_fdx_sel(cfg_10m_fdx_sel), .cfg_lock_sel(cfg_lock_sel),
    .iso_strap(iso_strap), .iso_wr_en(iso_wr_en), .iso_wr_data(iso_wr_data),
    .iso_ctl(iso_ctl), .led_tx_n(led_tx_n), .led_rx_n(led_rx_n),
    .led_link_n(led_link_n), .led_dpx_n(led_dpx_n), .led_col_n(led_col_n));

  // Behavioural reference: integer hold counters updated per clock edge
  int  m_tx, m_rx, m_col;
  bit  m_txs, m_locks;
  bit  e_tx, e_rx, e_link, e_dpx, e_col, e_iso;

  always @(posedge clk) begin
    cyc++;
    started = 1;
    if (rst) begin
      m_tx = 0; m_rx = 0; m_col = 0;
      e_tx = 1; e_rx = 1; e_link = 1; e_dpx = 1; e_col = 1;
      e_iso = iso_strap;
    end else begin
      if (cfg_tx_disc_sel != m_txs) m_tx = 0;
      else if (tx_evt && !cfg_tx_disc_sel) m_tx = S;
      else if (m_tx > 0) m_tx--;
      if (rx_evt) m_rx = S; else if (m_rx > 0) m_rx--;
      if (cfg_lock_sel != m_locks) m_col = 0;
      else if (col_evt && !cfg_lock_sel) m_col = S;
      else if (m_col > 0) m_col--;
      e_tx   = cfg_tx_disc_sel ? !disc_det : !(m_tx > 0);
      e_rx   = !(m_rx > 0);
      e_link = !link_ok;
      e_dpx  = (spd_100 || cfg_10m_fdx_sel) ? !fdx : !pol_ok;
      e_col  = cfg_lock_sel ? !dscr_lock : !(m_col > 0);
      if (iso_wr_en) e_iso = iso_wr_data;
    end
    m_txs = cfg_tx_disc_sel;
    m_locks = cfg_lock_sel;
  end

  task automatic chk(input string tag, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] cycle %0d: actual %b expected %b", tag, phase, cyc, act, exp);
    end
  endtask

  // Compare every output on every clock, away from the edge (R12 latency is implicit)
  always @(negedge clk) begin
    if (started) begin
      if (rst) begin
        chk("R1 led_tx_n", led_tx_n, e_tx);
        chk("R1 led_rx_n", led_rx_n, e_rx);
        chk("R1 led_link_n", led_link_n, e_link);
        chk("R1 led_dpx_n", led_dpx_n, e_dpx);
        chk("R1 led_col_n", led_col_n, e_col);
        chk("R10 iso_ctl", iso_ctl, e_iso);
      end else begin
        chk(cfg_tx_disc_sel ? "R3 led_tx_n" : "R2 R9 R12 led_tx_n", led_tx_n, e_tx);
        chk("R4 led_rx_n", led_rx_n, e_rx);
        chk("R5 R12 led_link_n", led_link_n, e_link);
        chk(spd_100 ? "R6 led_dpx_n" : "R7 led_dpx_n", led_dpx_n, e_dpx);
        chk("R8 R9 led_col_n", led_col_n, e_col);
        chk("R11 iso_ctl", iso_ctl, e_iso);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tx(); tx_evt = 1; step(1); tx_evt = 0; endtask
  task automatic pulse_rx(); rx_evt = 1; step(1); rx_evt = 0; endtask
  task automatic pulse_col(); col_evt = 1; step(1); col_evt = 0; endtask

  initial begin : watchdog
    wait (cyc > 100000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    phase = "reset R1 R10";
    step(4);
    rst = 0; iso_strap = 0;
    step(2);
    phase = "tx single R2"; pulse_tx(); step(S + 3);
    phase = "tx retrigger R2"; pulse_tx(); step(4); pulse_tx(); step(S + 3);
    phase = "tx back-to-back R2"; tx_evt = 1; step(5); tx_evt = 0; step(S + 2);
    phase = "rx R4"; pulse_rx(); step(3); pulse_rx(); step(S + 3);
    phase = "col R8"; pulse_col(); step(S + 3);
    phase = "link R5"; link_ok = 1; step(3); link_ok = 0; step(2); link_ok = 1;
    phase = "duplex R6 R7";
    for (int k = 0; k < 16; k++) begin
      {spd_100, cfg_10m_fdx_sel, fdx, pol_ok} = 4'(k);
      step(2);
    end
    phase = "disc R3"; cfg_tx_disc_sel = 1; step(1); disc_det = 1; step(2);
    pulse_tx(); disc_det = 0; step(3); cfg_tx_disc_sel = 0; step(2);
    phase = "lock R8"; cfg_lock_sel = 1; dscr_lock = 1; step(2); pulse_col();
    dscr_lock = 0; step(3); cfg_lock_sel = 0; step(2);
    phase = "tx switch clear R9"; pulse_tx(); step(2);
    cfg_tx_disc_sel = 1; step(1); cfg_tx_disc_sel = 0; step(S + 2);
    phase = "col switch clear R9"; pulse_col(); step(1);
    cfg_lock_sel = 1; step(2); cfg_lock_sel = 0; step(S + 2);
    phase = "iso write R11"; iso_strap = 1; step(2);
    iso_wr_data = 1; iso_wr_en = 1; step(1); iso_wr_en = 0; iso_wr_data = 0; step(2);
    iso_wr_en = 1; step(1); iso_wr_en = 0; step(2);
    phase = "mid reset R1 R10"; pulse_tx(); rst = 1; iso_strap = 0; step(3);
    rst = 0; iso_strap = 1; step(3);
    phase = "random R2 R3 R8 R9";
    for (int k = 0; k < 3000; k++) begin
      tx_evt = ($urandom_range(0, 5) == 0);
      rx_evt = ($urandom_range(0, 7) == 0);
      col_evt = ($urandom_range(0, 9) == 0);
      link_ok = $urandom_range(0, 1);
      fdx = $urandom_range(0, 1);
      pol_ok = $urandom_range(0, 1);
      dscr_lock = $urandom_range(0, 1);
      disc_det = $urandom_range(0, 1);
      if ($urandom_range(0, 15) == 0) spd_100 = ~spd_100;
      if ($urandom_range(0, 11) == 0) cfg_tx_disc_sel = ~cfg_tx_disc_sel;
      if ($urandom_range(0, 11) == 0) cfg_lock_sel = ~cfg_lock_sel;
      if ($urandom_range(0, 15) == 0) cfg_10m_fdx_sel = ~cfg_10m_fdx_sel;
      iso_wr_en = ($urandom_range(0, 20) == 0);
      iso_wr_data = $urandom_range(0, 1);
      iso_strap = $urandom_range(0, 1);
      rst = ($urandom_range(0, 400) == 0);
      step(1);
    end
    rst = 0; tx_evt = 0; rx_evt = 0; col_evt = 0; iso_wr_en = 0;
    step(S + 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule